// File: doc/BRIEF.md
# Burst-to-Single-Beat Write Bridge

This block sits between a burst-capable write master and a register-style target that only takes one data beat per write. It accepts an AXI4 write burst on its upstream port and issues one AXI-Lite write per beat on its downstream port. Each downstream write carries the start address advanced by one bus word per beat. Only incrementing bursts of full bus width are handled. A single ID is carried through to the response.

The downstream target returns one response per beat. The bridge folds these into one upstream write response per burst. A small queue holds the beat count and ID of every accepted burst. A counter tracks how many downstream responses the oldest burst has already returned. When that burst's final response is taken, the queue entry is retired and the merged response is raised upstream. The merged code is the most severe of the per-beat codes.

Downstream responses pass through a one-entry holding register. The downstream response ready is therefore only high while that register is free, so a stalled upstream response channel pushes back on the target instead of losing data.

Top module: `axi_burst_lite_wr`

## Requirements
- R1: After reset, sAwReady is 1 and mBReady is 1, while mAwValid, mWValid and sBValid are 0.
- R2: A burst accepted with length field L yields exactly L+1 downstream address handshakes and L+1 downstream data handshakes. L=0 means one beat and L=255 means 256 beats. mAwValid is high from the cycle after acceptance until the last address is taken.
- R3: The downstream address for beat k is the burst start address plus k times DATA_W/8. While mAwValid is high and mAwReady is low, the address holds.
- R4: Write data and byte strobes reach the downstream port unchanged in the same cycle. The beat count comes from the length field only: a beat flagged as last before the counted end does not end the burst, and the remaining beats are still accepted.
- R5: Each burst raises sBValid exactly once, and never before all of its downstream responses have been taken. When sBReady is held high, sBValid is high two cycles after the handshake of the burst's final downstream response.
- R6: sBResp is the highest code among the burst's per-beat responses, using the order OKAY=0 < EXOKAY=1 < SLVERR=2 < DECERR=3. This merged value is cleared between bursts.
- R7: sBId equals the ID given with the burst, and responses come back in burst acceptance order.
- R8: After a downstream response handshake, mBReady is low in the next cycle. While sBValid is high and sBReady is low, sBValid, sBId and sBResp hold.
- R9: When FIFO_DEPTH bursts are awaiting completion, sAwReady stays low.
- R10: Single-beat bursts sent back to back each complete with their own response, including when a response arrives in the same cycle that the previous burst completes.
- R11: sWReady is high only when mWReady is high and the burst in progress still has data beats left to take. No data beat is taken before its burst's address has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sAwValid | input | 1 | Upstream burst address valid |
| sAwReady | output | 1 | Upstream burst address ready |
| sAwId | input | ID_W | Burst ID |
| sAwAddr | input | ADDR_W | Burst start address |
| sAwLen | input | 8 | Beats in burst minus one |
| sWValid | input | 1 | Upstream data valid |
| sWReady | output | 1 | Upstream data ready |
| sWData | input | DATA_W | Upstream write data |
| sWStrb | input | DATA_W/8 | Upstream byte strobes |
| sWLast | input | 1 | Upstream last-beat flag (not trusted) |
| sBValid | output | 1 | Upstream merged response valid |
| sBReady | input | 1 | Upstream response ready |
| sBId | output | ID_W | ID of the completed burst |
| sBResp | output | 2 | Merged response code |
| mAwValid | output | 1 | Downstream address valid |
| mAwReady | input | 1 | Downstream address ready |
| mAwAddr | output | ADDR_W | Downstream beat address |
| mWValid | output | 1 | Downstream data valid |
| mWReady | input | 1 | Downstream data ready |
| mWData | output | DATA_W | Downstream write data |
| mWStrb | output | DATA_W/8 | Downstream byte strobes |
| mBValid | input | 1 | Downstream response valid |
| mBReady | output | 1 | Downstream response ready |
| mBResp | input | 2 | Downstream response code |

## Verification
The following latencies apply:
- A downstream address is offered in the cycle after its burst is accepted, and each following address comes in the cycle after the previous one is taken.
- Data beats cross in the same cycle they are accepted.
- The merged response appears two cycles after the final downstream response handshake: one cycle in the holding register, one to merge.

The bench samples every port one nanosecond before each rising edge. Its model advances its queues only on the handshakes seen in that sample, so a value expected "next cycle" is compared in the following sample. The exact two-cycle response latency is enforced only while the upstream ready is held high. Under random stalls, the bench checks the lower bound of two cycles and the hold behaviour instead.

// File: rtl/axbl_pkg.sv
`timescale 1ns/1ps
package axbl_pkg;

  localparam int LEN_W = 8;

  typedef struct packed {
    logic burstLoad;  // upstream burst accepted, queue entry pushed
    logic awStep;     // downstream address taken, advance to next beat
    logic skidLoad;   // downstream response captured in holding register
    logic respTake;   // held response consumed by the merge stage
    logic respDone;   // consumed response closes the head burst
  } axblStrobes_t;

  function automatic logic [1:0] worseResp(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/axbl_cnt_fifo.sv
`timescale 1ns/1ps
module axbl_cnt_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = PTR_W + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [FILL_W-1:0] fill;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  assign headData = store[rdPtr];
  assign full     = (fill == FILL_W'(DEPTH));
  assign empty    = (fill == '0);

endmodule

// File: rtl/axbl_ctrl.sv
`timescale 1ns/1ps
module axbl_ctrl
  import axbl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sAwValid,
  input  logic [LEN_W-1:0] sAwLen,
  input  logic             sWValid,
  input  logic             mAwReady,
  input  logic             mWReady,
  input  logic             mBValid,
  input  logic             sBReady,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic [LEN_W-1:0] headLen,
  output logic             sAwReady,
  output logic             mAwValid,
  output logic             sWReady,
  output logic             mWValid,
  output logic             mBReady,
  output logic             sBValid,
  output axblStrobes_t     strb
);
  localparam int CNT_W = LEN_W + 1;

  logic             busy;
  logic [LEN_W-1:0] burstLen;
  logic [CNT_W-1:0] awCnt, wCnt, awCntNext, wCntNext, lastIdx;
  logic [LEN_W-1:0] respCnt;
  logic             skidValid, sBValidQ;
  logic             awPending, wPending, awFire, wFire, finishing, lastResp;

  assign lastIdx   = {1'b0, burstLen};
  assign awPending = busy && (awCnt <= lastIdx);
  assign wPending  = busy && (wCnt <= lastIdx);

  assign sAwReady = !busy && !fifoFull;
  assign mAwValid = awPending;
  assign mWValid  = sWValid && wPending;
  assign sWReady  = mWReady && wPending;
  assign mBReady  = !skidValid;
  assign sBValid  = sBValidQ;

  assign awFire    = mAwValid && mAwReady;
  assign wFire     = mWValid && mWReady;
  assign awCntNext = awCnt + {{LEN_W{1'b0}}, awFire};
  assign wCntNext  = wCnt + {{LEN_W{1'b0}}, wFire};
  assign finishing = busy && (awCntNext > lastIdx) && (wCntNext > lastIdx);

  assign lastResp = (respCnt == headLen);

  always_comb begin
    strb           = '0;
    strb.burstLoad = sAwValid && sAwReady;
    strb.awStep    = awFire;
    strb.skidLoad  = mBValid && mBReady;
    strb.respTake  = skidValid && !fifoEmpty && (!lastResp || !sBValidQ || sBReady);
    strb.respDone  = strb.respTake && lastResp;
  end

  // request side: one burst expanded at a time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      burstLen <= '0;
      awCnt    <= '0;
      wCnt     <= '0;
    end else if (strb.burstLoad) begin
      busy     <= 1'b1;
      burstLen <= sAwLen;
      awCnt    <= '0;
      wCnt     <= '0;
    end else begin
      awCnt <= awCntNext;
      wCnt  <= wCntNext;
      if (finishing) busy <= 1'b0;
    end
  end

  // response side: holding register, per-burst counter, upstream valid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skidValid <= 1'b0;
      respCnt   <= '0;
      sBValidQ  <= 1'b0;
    end else begin
      if (strb.skidLoad)      skidValid <= 1'b1;
      else if (strb.respTake) skidValid <= 1'b0;

      if (strb.respDone)      respCnt <= '0;
      else if (strb.respTake) respCnt <= respCnt + 1'b1;

      if (strb.respDone)      sBValidQ <= 1'b1;
      else if (sBReady)       sBValidQ <= 1'b0;
    end
  end

endmodule

// File: rtl/axbl_datapath.sv
`timescale 1ns/1ps
module axbl_datapath
  import axbl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  axblStrobes_t      strb,
  input  logic [ADDR_W-1:0] sAwAddr,
  input  logic [LEN_W-1:0]  sAwLen,
  input  logic [ID_W-1:0]   sAwId,
  input  logic [1:0]        mBResp,
  output logic [ADDR_W-1:0] mAwAddr,
  output logic [ID_W-1:0]   sBId,
  output logic [1:0]        sBResp,
  output logic [LEN_W-1:0]  headLen,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int ENTRY_W = LEN_W + ID_W;

  logic [ADDR_W-1:0]  addrQ;
  logic [1:0]         skidResp, accResp;
  logic [ENTRY_W-1:0] headEntry;
  logic [ID_W-1:0]    headId;

  axbl_cnt_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_cntFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.burstLoad),
    .pushData ({sAwId, sAwLen}),
    .pop      (strb.respDone),
    .headData (headEntry),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  assign headLen = headEntry[LEN_W-1:0];
  assign headId  = headEntry[ENTRY_W-1:LEN_W];
  assign mAwAddr = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      skidResp <= '0;
      accResp  <= '0;
      sBResp   <= '0;
      sBId     <= '0;
    end else begin
      if (strb.burstLoad)   addrQ <= sAwAddr;
      else if (strb.awStep) addrQ <= addrQ + ADDR_W'(BYTES);

      if (strb.skidLoad) skidResp <= mBResp;

      if (strb.respDone) begin
        accResp <= '0;
        sBResp  <= worseResp(accResp, skidResp);
        sBId    <= headId;
      end else if (strb.respTake) begin
        accResp <= worseResp(accResp, skidResp);
      end
    end
  end

endmodule

// File: rtl/axi_burst_lite_wr.sv
`timescale 1ns/1ps
module axi_burst_lite_wr
  import axbl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ID_W       = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sAwValid,
  output logic                sAwReady,
  input  logic [ID_W-1:0]     sAwId,
  input  logic [ADDR_W-1:0]   sAwAddr,
  input  logic [7:0]          sAwLen,
  input  logic                sWValid,
  output logic                sWReady,
  input  logic [DATA_W-1:0]   sWData,
  input  logic [DATA_W/8-1:0] sWStrb,
  input  logic                sWLast,
  output logic                sBValid,
  input  logic                sBReady,
  output logic [ID_W-1:0]     sBId,
  output logic [1:0]          sBResp,
  output logic                mAwValid,
  input  logic                mAwReady,
  output logic [ADDR_W-1:0]   mAwAddr,
  output logic                mWValid,
  input  logic                mWReady,
  output logic [DATA_W-1:0]   mWData,
  output logic [DATA_W/8-1:0] mWStrb,
  input  logic                mBValid,
  output logic                mBReady,
  input  logic [1:0]          mBResp
);
  localparam int BYTES = DATA_W / 8;

  axblStrobes_t       strb;
  logic               fifoFull, fifoEmpty;
  logic [LEN_W-1:0]   headLen;

  assign mWData = sWData;
  assign mWStrb = sWStrb;

  axbl_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sAwValid  (sAwValid),
    .sAwLen    (sAwLen),
    .sWValid   (sWValid),
    .mAwReady  (mAwReady),
    .mWReady   (mWReady),
    .mBValid   (mBValid),
    .sBReady   (sBReady),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .headLen   (headLen),
    .sAwReady  (sAwReady),
    .mAwValid  (mAwValid),
    .sWReady   (sWReady),
    .mWValid   (mWValid),
    .mBReady   (mBReady),
    .sBValid   (sBValid),
    .strb      (strb)
  );

  axbl_datapath #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .DEPTH  (FIFO_DEPTH),
    .BYTES  (BYTES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sAwAddr   (sAwAddr),
    .sAwLen    (sAwLen),
    .sAwId     (sAwId),
    .mBResp    (mBResp),
    .mAwAddr   (mAwAddr),
    .sBId      (sBId),
    .sBResp    (sBResp),
    .headLen   (headLen),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty)
  );

endmodule

// File: rtl/axbl_checker.sv
`timescale 1ns/1ps
module axbl_checker #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sBValid,
  input logic              sBReady,
  input logic [ID_W-1:0]   sBId,
  input logic [1:0]        sBResp,
  input logic              mAwValid,
  input logic              mAwReady,
  input logic [ADDR_W-1:0] mAwAddr,
  input logic              mWValid,
  input logic              mWReady,
  input logic              sWValid,
  input logic              sWReady,
  input logic              sWLast,
  input logic              mBValid,
  input logic              mBReady
);

  assert_bhold_R8: assert property (@(posedge clk) disable iff (!rstN)
    sBValid && !sBReady |=> sBValid && $stable(sBId) && $stable(sBResp));

  assert_bready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    mBValid && mBReady |=> !mBReady);

  assert_awhold_R3: assert property (@(posedge clk) disable iff (!rstN)
    mAwValid && !mAwReady |=> mAwValid && $stable(mAwAddr));

  assert_wready_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    sWReady |-> mWReady);

  assert_wlast_passed_R4: assert property (@(posedge clk) disable iff (!rstN)
    sWValid && sWReady && sWLast |-> mWValid);

  assert_bvalid_after_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sBValid) |-> !$past(mBReady));

endmodule

bind axi_burst_lite_wr axbl_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sBValid  (sBValid),
  .sBReady  (sBReady),
  .sBId     (sBId),
  .sBResp   (sBResp),
  .mAwValid (mAwValid),
  .mAwReady (mAwReady),
  .mAwAddr  (mAwAddr),
  .mWValid  (mWValid),
  .mWReady  (mWReady),
  .sWValid  (sWValid),
  .sWReady  (sWReady),
  .sWLast   (sWLast),
  .mBValid  (mBValid),
  .mBReady  (mBReady)
);

// File: tb/axi_burst_lite_wr_tb.sv
`timescale 1ns/1ps
module axi_burst_lite_wr_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        sAwValid = 0, sAwReady;
  logic [3:0]  sAwId = 0;
  logic [31:0] sAwAddr = 0;
  logic [7:0]  sAwLen = 0;
  logic        sWValid = 0, sWReady;
  logic [31:0] sWData = 0;
  logic [3:0]  sWStrb = 0;
  logic        sWLast = 0;
  logic        sBValid, sBReady = 1;
  logic [3:0]  sBId;
  logic [1:0]  sBResp;
  logic        mAwValid, mAwReady = 1;
  logic [31:0] mAwAddr;
  logic        mWValid, mWReady = 1;
  logic [31:0] mWData;
  logic [3:0]  mWStrb;
  logic        mBValid = 0, mBReady;
  logic [1:0]  mBResp = 0;

  axi_burst_lite_wr #(.ADDR_W(32), .DATA_W(32), .ID_W(4), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwId(sAwId), .sAwAddr(sAwAddr), .sAwLen(sAwLen),
    .sWValid(sWValid), .sWReady(sWReady), .sWData(sWData), .sWStrb(sWStrb), .sWLast(sWLast),
    .sBValid(sBValid), .sBReady(sBReady), .sBId(sBId), .sBResp(sBResp),
    .mAwValid(mAwValid), .mAwReady(mAwReady), .mAwAddr(mAwAddr),
    .mWValid(mWValid), .mWReady(mWReady), .mWData(mWData), .mWStrb(mWStrb),
    .mBValid(mBValid), .mBReady(mBReady), .mBResp(mBResp)
  );

  typedef struct packed { logic [31:0] addr; logic [8:0] len; logic [3:0] id; } awItem_t;
  typedef struct packed { logic [31:0] data; logic [3:0] strb; logic last; } wItem_t;
  typedef struct packed { logic [3:0] id; logic [9:0] beats; logic [9:0] got; logic [1:0] worst; int lastCyc; } track_t;

  awItem_t     awQ[$];
  wItem_t      wQ[$];
  logic [1:0]  respQ[$];
  logic [31:0] expAddr[$];
  track_t      trackQ[$];
  track_t      expB[$];

  int checks = 0, errors = 0, cyc = 0;
  int wRemain = 0, liteAwN = 0, liteWN = 0, bRaised = 0, accepted = 0;
  bit rndReady = 0, bFast = 1, respEnable = 1, bTaken = 0, prevBTake = 0, prevStall = 0;
  logic [3:0]  prevId;
  logic [1:0]  prevResp;
  logic [31:0] seed = 32'h1234_5678;

  function bit coin();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[3];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic addBurst(input int id, input logic [31:0] addr, input int len, input int lastAt,
                          input int e1, input int c1, input int e2, input int c2);
    awItem_t a;
    a.addr = addr; a.len = 9'(len); a.id = 4'(id);
    awQ.push_back(a);
    for (int k = 0; k <= len; k++) begin
      wItem_t w;
      w.data = {4'(id), 4'hA, 8'h5C, 16'(k)} ^ addr;
      w.strb = k[0] ? 4'h3 : 4'hF;
      w.last = (k == lastAt);
      wQ.push_back(w);
      respQ.push_back((k == e1) ? 2'(c1) : ((k == e2) ? 2'(c2) : 2'd0));
    end
  endtask

  task automatic step();
    @(negedge clk);
    sAwValid = (awQ.size() > 0);
    if (awQ.size() > 0) begin
      sAwAddr = awQ[0].addr; sAwLen = awQ[0].len[7:0]; sAwId = awQ[0].id;
    end
    sWValid = (wQ.size() > 0) && (!rndReady || coin());
    if (wQ.size() > 0) begin
      sWData = wQ[0].data; sWStrb = wQ[0].strb; sWLast = wQ[0].last;
    end
    mAwReady = !rndReady || coin();
    mWReady  = !rndReady || coin();
    sBReady  = bFast ? 1'b1 : coin();
    if (bTaken) begin mBValid = 0; bTaken = 0; end
    if (!mBValid && respEnable && liteAwN > bRaised && liteWN > bRaised && respQ.size() > 0
        && (!rndReady || coin())) begin
      mBValid = 1; mBResp = respQ.pop_front(); bRaised++;
    end
    #4;
    cyc++;
    // R8: downstream ready drops after a taken response
    if (prevBTake) chk(!mBReady, "R8", "mBReady after take", mBReady, 0);
    prevBTake = 0;
    // R2: address valid tracks outstanding downstream addresses
    chk(mAwValid == (expAddr.size() > 0), "R2", "mAwValid", mAwValid, expAddr.size() > 0);
    if (mAwValid && mAwReady && expAddr.size() > 0) begin
      chk(mAwAddr == expAddr[0], "R3", "beat address", mAwAddr, expAddr[0]);
      void'(expAddr.pop_front());
      liteAwN++;
    end
    // R11: data ready only with beats left
    chk(sWReady == (mWReady && wRemain > 0), "R11", "sWReady", sWReady, mWReady && wRemain > 0);
    if (sWValid && sWReady && wQ.size() > 0) begin
      chk(mWValid && mWData == wQ[0].data && mWStrb == wQ[0].strb, "R4", "data passthrough",
          mWData, wQ[0].data);
      void'(wQ.pop_front());
      wRemain--;
      liteWN++;
    end
    if (sAwValid && sAwReady && awQ.size() > 0) begin
      awItem_t a = awQ.pop_front();
      track_t t;
      for (int k = 0; k <= int'(a.len); k++) expAddr.push_back(a.addr + 32'(k * 4));
      wRemain += int'(a.len) + 1;
      t.id = a.id; t.beats = 10'(a.len) + 10'd1; t.got = 0; t.worst = 0; t.lastCyc = 0;
      trackQ.push_back(t);
      accepted++;
    end
    // upstream response checks
    if (prevStall)
      chk(sBValid && sBId == prevId && sBResp == prevResp, "R8", "stalled response hold", sBResp, prevResp);
    if (sBValid) begin
      if (expB.size() == 0) chk(0, "R5", "unexpected sBValid", 1, 0);
      else begin
        chk(cyc >= expB[0].lastCyc + 2, "R5", "response too early", cyc, expB[0].lastCyc + 2);
        if (sBReady) begin
          chk(sBId == expB[0].id, "R7", "sBId", sBId, expB[0].id);
          chk(sBResp == expB[0].worst, "R6", "merged code", sBResp, expB[0].worst);
          void'(expB.pop_front());
        end
      end
    end else if (bFast && expB.size() > 0 && cyc >= expB[0].lastCyc + 2) begin
      chk(0, "R5", "response late", cyc, expB[0].lastCyc + 2);
    end
    prevStall = sBValid && !sBReady;
    prevId = sBId; prevResp = sBResp;
    // downstream response bookkeeping
    if (mBValid && mBReady) begin
      bTaken = 1; prevBTake = 1;
      if (trackQ.size() == 0) chk(0, "R2", "response without burst", 1, 0);
      else begin
        track_t t = trackQ[0];
        t.got = t.got + 1'b1;
        if (mBResp > t.worst) t.worst = mBResp;
        if (t.got == t.beats) begin
          t.lastCyc = cyc;
          expB.push_back(t);
          void'(trackQ.pop_front());
        end else trackQ[0] = t;
      end
    end
  endtask

  task automatic drain(input string tag);
    int lim = cyc + 5000;
    while ((awQ.size() || wQ.size() || expAddr.size() || trackQ.size() || expB.size()) && cyc < lim)
      step();
    chk(cyc < lim, "R5", {"drain ", tag}, cyc, lim);
    repeat (3) step();
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    // R1 reset state
    chk(sAwReady == 1, "R1", "sAwReady", sAwReady, 1);
    chk(mBReady == 1, "R1", "mBReady", mBReady, 1);
    chk(!mAwValid && !mWValid && !sBValid, "R1", "valids", {mAwValid, mWValid, sBValid}, 0);

    // R10: back-to-back single-beat bursts
    addBurst(1, 32'h100, 0, 0, -1, 0, -1, 0);
    addBurst(2, 32'h200, 0, 0, 0, 2, -1, 0);
    addBurst(3, 32'h300, 0, 0, -1, 0, -1, 0);
    drain("R10");

    // R6 / R3 / R7: merged codes and address steps
    addBurst(4, 32'h1000, 3, 3, 1, 2, 2, 1);
    addBurst(5, 32'h2000, 1, 1, 0, 3, 1, 2);
    addBurst(6, 32'h3000, 2, 2, -1, 0, -1, 0);
    addBurst(7, 32'h4000, 0, 0, 0, 1, -1, 0);
    drain("R6");

    // R4: early last flag
    addBurst(8, 32'h5000, 3, 0, -1, 0, -1, 0);
    addBurst(9, 32'h6000, 0, 0, -1, 0, -1, 0);
    drain("R4");

    // R11: data offered before address
    begin
      awItem_t held;
      addBurst(10, 32'h7000, 1, 1, -1, 0, -1, 0);
      held = awQ.pop_front();
      repeat (5) begin
        step();
        chk(!sWReady, "R11", "no data before address", sWReady, 0);
      end
      awQ.push_back(held);
      drain("R11");
    end

    // R2 boundary: 256-beat burst
    addBurst(11, 32'h8000, 255, 255, 200, 2, -1, 0);
    drain("R2");

    // R9: queue full with responses held back
    respEnable = 0;
    for (int i = 0; i < 6; i++) addBurst(i, 32'h9000 + 32'(i * 64), 0, 0, -1, 0, -1, 0);
    accepted = 0;
    repeat (40) step();
    chk(accepted == DEPTH, "R9", "bursts accepted while full", accepted, DEPTH);
    chk(!sAwReady, "R9", "sAwReady while full", sAwReady, 0);
    respEnable = 1;
    drain("R9");

    // R8: random stalls on every channel
    rndReady = 1; bFast = 0;
    for (int i = 0; i < 10; i++)
      addBurst(i, 32'hA000 + 32'(i * 256), (i * 3) % 8, (i * 3) % 8, i % 3, i % 4, 2, 1);
    drain("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule